// File: doc/BRIEF.md
# Sponge-Style Authenticated Encryption Mode Controller

This block runs the mode of operation around an external 128-bit block cipher. It does not contain the cipher. A session starts with a one-cycle `start` pulse, which latches the direction, a 120-bit nonce and, for decryption, a 128-bit reference tag. The chaining state starts at zero.

Associated-data blocks of 64 bits arrive first and are absorbed one cipher call at a time. Each block is XORed into the upper half of the state, and the lower half is carried through. After the last associated-data block, the controller makes one call on its own to absorb the nonce, padded to 128 bits with a domain byte. The result is the initial value for the message phase.

Message blocks are then encrypted or decrypted against the upper state half, and each result leaves on the output port. Encryption feeds the ciphertext back into the state, and decryption feeds back the ciphertext it received. The output of the call that follows the last message block is the 128-bit tag. In decryption that tag is compared with the reference tag.

Top module: `sponge_aead_ctrl`

## Requirements
- R1: After reset, `in_ready`, `c_start`, `out_valid`, `tag_valid` and `tag_ok` are all low.
- R2: An accepted associated-data block produces a cipher call whose input is built as follows. The upper 64 bits are the padded block XOR the upper state half. The lower 64 bits are the lower state half, XORed with 8'h01 in bits [7:0] when `in_last` is set. The state is zero at `start`, and after every call it is the cipher output.
- R3: After the call for the last associated-data block completes, one call is issued without consuming input. Its input is the state XOR {nonce, 8'h02}, with the nonce in bits [127:8].
- R4: In encryption, a message block M gives `out_data` = M XOR upper state half. The next cipher input is {that ciphertext with padding, lower half}.
- R5: In decryption, a block C gives `out_data` = C XOR upper state half. The next cipher input upper half is C itself on the valid bytes.
- R6: `in_bytes` (1 to 8) counts the valid bytes, which occupy the top of the block starting at bits [63:56]. A short block is padded with byte 8'h80 right after the valid bytes, then zeros. Input bits in invalid bytes have no effect. Invalid output bytes read zero, and `out_bytes` equals `in_bytes`.
- R7: The last message block XORs 8'h03 into bits [7:0] of the lower half. The output of that call appears on `tag` with a one-cycle `tag_valid` in the cycle after `c_done`. `tag` holds until the next `start`.
- R8: `c_start` is high for exactly one cycle per call, and `c_in` stays stable between calls. `in_ready` is low from block acceptance until `c_done`.
- R9: `tag_ok` rises with `tag_valid` only in decryption and only on an exact 128-bit match with `exp_tag`. It stays low in encryption.
- R10: `start` has no effect while a session is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Session start pulse, sampled only when idle |
| decrypt | input | 1 | 1 selects decryption for the session |
| nonce | input | 120 | Session nonce |
| exp_tag | input | 128 | Reference tag for decryption |
| in_valid | input | 1 | Input block present |
| in_ready | output | 1 | Controller can take a block |
| in_data | input | 64 | Associated-data, plaintext or ciphertext block |
| in_bytes | input | 4 | Valid byte count of the block, 1 to 8 |
| in_last | input | 1 | Block is the last of its phase |
| out_valid | output | 1 | Output block present, one cycle |
| out_data | output | 64 | Ciphertext or recovered plaintext |
| out_bytes | output | 4 | Valid byte count of the output block |
| tag_valid | output | 1 | Tag ready, one cycle |
| tag | output | 128 | Computed tag |
| tag_ok | output | 1 | Decryption tag matched |
| c_start | output | 1 | Cipher call request, one cycle |
| c_in | output | 128 | Cipher input block |
| c_done | input | 1 | Cipher result ready |
| c_out | input | 128 | Cipher output block |

## Verification
The bench checks three ways a data block can go wrong.
- Short final blocks: the bench fills their unused input bytes with junk. A controller that masks late or pads in the wrong place leaks that junk into the cipher input or the output, and the very next cipher input differs.
- Decryption feedback: decryption runs the ciphertext of an earlier encryption back through the controller, so the recovered plaintext and tag must match. A version that feeds back plaintext instead of ciphertext keeps producing correct outputs for the first block but diverges on the second block and on the tag.
- Domain bytes: swapping or dropping a domain byte shows up only as a wrong lower half in one cipher input.

The bench also covers the session and handshake rules. It sends a stray `start` in the middle of a session. It checks that `tag_ok` stays low in encryption even when the reference tag equals the computed one. It varies the cipher latency, including a zero-wait reply.

// File: rtl/sponge_aead_ctrl.sv
module sponge_aead_ctrl #(
  parameter int BLK_W   = 64,
  parameter int NONCE_W = 120
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   decrypt,
  input  logic [NONCE_W-1:0]     nonce,
  input  logic [2*BLK_W-1:0]     exp_tag,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [BLK_W-1:0]       in_data,
  input  logic [3:0]             in_bytes,
  input  logic                   in_last,
  output logic                   out_valid,
  output logic [BLK_W-1:0]       out_data,
  output logic [3:0]             out_bytes,
  output logic                   tag_valid,
  output logic [2*BLK_W-1:0]     tag,
  output logic                   tag_ok,
  output logic                   c_start,
  output logic [2*BLK_W-1:0]     c_in,
  input  logic                   c_done,
  input  logic [2*BLK_W-1:0]     c_out
);
  localparam int ST_W  = 2 * BLK_W;
  localparam int DOM_W = ST_W - NONCE_W;
  localparam logic [DOM_W-1:0] DOM_AD    = DOM_W'(1);
  localparam logic [DOM_W-1:0] DOM_NONCE = DOM_W'(2);
  localparam logic [DOM_W-1:0] DOM_MSG   = DOM_W'(3);

  typedef enum logic [2:0] {S_IDLE, S_AD, S_NONCE, S_MSG, S_WAIT} phase_t;

  phase_t                st, nxt;
  logic                  dec_q;
  logic [NONCE_W-1:0]    nonce_q;
  logic [ST_W-1:0]       exp_q, state;

  logic [BLK_W-1:0] t_up, t_lo, mask, pad, xin, absorbed, out_blk;
  logic [6:0]       sh;
  logic [DOM_W-1:0] dom;
  logic [ST_W-1:0]  call_in;

  assign t_up     = state[ST_W-1:BLK_W];
  assign t_lo     = state[BLK_W-1:0];
  assign sh       = {in_bytes, 3'b000};
  assign mask     = ~({BLK_W{1'b1}} >> sh);
  assign pad      = {1'b1, {(BLK_W-1){1'b0}}} >> sh;
  assign xin      = (dec_q && st == S_MSG) ? in_data : in_data ^ t_up;
  assign absorbed = (xin & mask) | ((pad ^ t_up) & ~mask);
  assign out_blk  = (in_data ^ t_up) & mask;
  assign dom      = !in_last ? '0 : (st == S_AD) ? DOM_AD : DOM_MSG;
  assign call_in  = {absorbed, t_lo ^ {{(BLK_W-DOM_W){1'b0}}, dom}};
  assign in_ready = (st == S_AD) || (st == S_MSG);
  assign tag      = state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      nxt       <= S_IDLE;
      dec_q     <= 1'b0;
      nonce_q   <= '0;
      exp_q     <= '0;
      state     <= '0;
      c_start   <= 1'b0;
      c_in      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_bytes <= '0;
      tag_valid <= 1'b0;
      tag_ok    <= 1'b0;
    end else begin
      c_start   <= 1'b0;
      out_valid <= 1'b0;
      tag_valid <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st      <= S_AD;
          dec_q   <= decrypt;
          nonce_q <= nonce;
          exp_q   <= exp_tag;
          state   <= '0;
          tag_ok  <= 1'b0;
        end
        S_AD, S_MSG: if (in_valid) begin
          c_start <= 1'b1;
          c_in    <= call_in;
          st      <= S_WAIT;
          if (st == S_MSG) begin
            out_valid <= 1'b1;
            out_data  <= out_blk;
            out_bytes <= in_bytes;
            nxt       <= in_last ? S_IDLE : S_MSG;
          end else begin
            nxt <= in_last ? S_NONCE : S_AD;
          end
        end
        S_NONCE: begin
          c_start <= 1'b1;
          c_in    <= state ^ {nonce_q, DOM_NONCE};
          nxt     <= S_MSG;
          st      <= S_WAIT;
        end
        S_WAIT: if (c_done) begin
          state <= c_out;
          st    <= nxt;
          if (nxt == S_IDLE) begin
            tag_valid <= 1'b1;
            tag_ok    <= dec_q && (c_out == exp_q);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sponge_aead_chk.sv
module sponge_aead_chk #(
  parameter int ST_W = 128
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_ready,
  input logic            c_start,
  input logic            c_done,
  input logic [ST_W-1:0] c_in,
  input logic            out_valid,
  input logic            tag_valid,
  input logic            tag_ok
);
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) c_start |=> !c_start); // R8
  AST_NO_READY_IN_CALL: assert property (@(posedge clk) disable iff (!rst_n) c_start |-> !in_ready); // R8
  AST_CIN_HELD: assert property (@(posedge clk) disable iff (!rst_n) !c_start |-> $stable(c_in)); // R8
  AST_OUT_WITH_CALL: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> c_start); // R4
  AST_TAG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) tag_valid |=> !tag_valid); // R7
  AST_TAG_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) tag_valid |-> $past(c_done)); // R7
  AST_TAG_IDLE: assert property (@(posedge clk) disable iff (!rst_n) tag_valid |-> !in_ready); // R7
  AST_OK_RISES_WITH_TAG: assert property (@(posedge clk) disable iff (!rst_n) $rose(tag_ok) |-> tag_valid); // R9
endmodule

bind sponge_aead_ctrl sponge_aead_chk #(.ST_W(2*BLK_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .c_start(c_start),
  .c_done(c_done), .c_in(c_in), .out_valid(out_valid),
  .tag_valid(tag_valid), .tag_ok(tag_ok)
);

// File: tb/test_sponge_aead_ctrl.sv
module test_sponge_aead_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, decrypt = 1'b0;
  logic [119:0] nonce = '0;
  logic [127:0] exp_tag = '0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [63:0] in_data = '0;
  logic [3:0] in_bytes = 4'd8;
  logic in_ready, out_valid, tag_valid, tag_ok, c_start;
  logic [63:0] out_data;
  logic [3:0] out_bytes;
  logic [127:0] tag, c_in;
  logic c_done = 1'b0;
  logic [127:0] c_out = '0;

  always #10 clk = ~clk;

  sponge_aead_ctrl i_sponge_aead_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .decrypt(decrypt), .nonce(nonce),
    .exp_tag(exp_tag), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_bytes(in_bytes), .in_last(in_last), .out_valid(out_valid), .out_data(out_data),
    .out_bytes(out_bytes), .tag_valid(tag_valid), .tag(tag), .tag_ok(tag_ok),
    .c_start(c_start), .c_in(c_in), .c_done(c_done), .c_out(c_out)
  );

  int compared = 0, mismatched = 0, ncalls = 0, tags_seen = 0;
  logic [127:0] q_cin[$];
  string        q_creq[$];
  logic [63:0]  q_out[$];
  logic [3:0]   q_nb[$];
  string        q_oreq[$];
  logic [127:0] q_tag[$];
  logic         q_ok[$];
  logic [63:0]  ad_blk[8], msg_in[8], ct[8], pt[8];

  task automatic chk(input bit good, input string req, input logic [127:0] act, input logic [127:0] exp);
    compared++;
    if (!good) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] perm(input logic [127:0] x);
    logic [127:0] r;
    r = {x[98:0], x[127:99]} ^ 128'h5a17_c3e9_0b2d_4f86_91a4_7e3c_d258_60bf;
    return r * 128'h9e37_79b9_7f4a_7c15_f39c_c060_5ced_c835;
  endfunction

  function automatic logic [63:0] bmask(input int n);
    logic [63:0] m = '0;
    for (int k = 0; k < n; k++) m[63-8*k -: 8] = 8'hFF;
    return m;
  endfunction

  function automatic logic [63:0] bpad(input int n);
    logic [63:0] p = '0;
    if (n < 8) p[63-8*n -: 8] = 8'h80;
    return p;
  endfunction

  // cipher stand-in with varying latency, including zero wait
  initial begin
    logic [127:0] cap;
    int lat;
    forever begin
      @(negedge clk);
      if (c_start) begin
        cap = c_in;
        lat = ncalls % 3;
        ncalls++;
        repeat (lat) @(negedge clk);
        c_done = 1'b1;
        c_out = perm(cap);
        @(negedge clk);
        c_done = 1'b0;
      end
    end
  end

  // reference comparison on every clock
  always @(negedge clk) if (rst_n) begin
    if (c_start) begin
      if (q_cin.size() == 0) chk(1'b0, "R8 unexpected call", c_in, '0);
      else chk(c_in === q_cin[0], q_creq[0], c_in, q_cin[0]);
      if (q_cin.size() != 0) begin void'(q_cin.pop_front()); void'(q_creq.pop_front()); end
      chk(!in_ready, "R8 ready during call", {127'd0, in_ready}, '0);
    end
    if (out_valid) begin
      if (q_out.size() == 0) chk(1'b0, "R4 unexpected output", {64'd0, out_data}, '0);
      else begin
        chk(out_data === q_out[0], q_oreq[0], {64'd0, out_data}, {64'd0, q_out[0]});
        chk(out_bytes === q_nb[0], "R6 out_bytes", {124'd0, out_bytes}, {124'd0, q_nb[0]});
        void'(q_out.pop_front()); void'(q_nb.pop_front()); void'(q_oreq.pop_front());
      end
    end
    if (tag_valid) begin
      if (q_tag.size() == 0) chk(1'b0, "R7 unexpected tag", tag, '0);
      else begin
        chk(tag === q_tag[0], "R7 tag value", tag, q_tag[0]);
        chk(tag_ok === q_ok[0], "R9 tag_ok", {127'd0, tag_ok}, {127'd0, q_ok[0]});
        void'(q_tag.pop_front()); void'(q_ok.pop_front());
      end
      tags_seen++;
    end
  end

  task automatic drive(input logic [63:0] d, input int n, input bit last);
    in_valid = 1'b1; in_data = d; in_bytes = 4'(n); in_last = last;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic session(input bit dec, input int nad, input int nmsg, input int lad, input int lmsg,
                         input logic [119:0] nn, input int tagsel, input bit poke);
    logic [127:0] s, cin;
    logic [63:0] m, d, padded, x, o;
    int n, target;
    s = '0;
    for (int i = 0; i < nad; i++) begin
      n = (i == nad - 1) ? lad : 8;
      m = bmask(n);
      padded = (ad_blk[i] & m) | bpad(n);
      cin = {padded ^ s[127:64], s[63:0] ^ ((i == nad - 1) ? 64'h01 : 64'h00)};
      q_cin.push_back(cin); q_creq.push_back((i == nad - 1) ? "R2 last AD call" : "R2 AD call");
      s = perm(cin);
    end
    cin = s ^ {nn, 8'h02};
    q_cin.push_back(cin); q_creq.push_back("R3 nonce call");
    s = perm(cin);
    for (int i = 0; i < nmsg; i++) begin
      n = (i == nmsg - 1) ? lmsg : 8;
      m = bmask(n);
      d = msg_in[i];
      if (!dec) begin
        padded = (d & m) | bpad(n);
        x = padded ^ s[127:64];
        o = x & m;
        ct[i] = o;
      end else begin
        o = (d ^ s[127:64]) & m;
        padded = o | bpad(n);
        x = padded ^ s[127:64];
      end
      q_out.push_back(o); q_nb.push_back(4'(n));
      q_oreq.push_back(dec ? ((n < 8) ? "R6 short decrypt" : "R5 decrypt") : ((n < 8) ? "R6 short encrypt" : "R4 encrypt"));
      cin = {x, s[63:0] ^ ((i == nmsg - 1) ? 64'h03 : 64'h00)};
      q_cin.push_back(cin); q_creq.push_back(dec ? "R5 feedback" : ((i == nmsg - 1) ? "R7 last message call" : "R4 feedback"));
      s = perm(cin);
    end
    q_tag.push_back(s);
    exp_tag = (tagsel == 1) ? s : (tagsel == 2) ? s ^ 128'h1 : 128'h0;
    q_ok.push_back(dec && tagsel == 1);
    target = tags_seen + 1;
    @(negedge clk);
    start = 1'b1; decrypt = dec; nonce = nn;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < nad; i++) begin
      drive(ad_blk[i], (i == nad - 1) ? lad : 8, i == nad - 1);
      if (poke && i == 0) begin
        start = 1'b1; decrypt = !dec; nonce = ~nn; exp_tag = ~exp_tag;
        @(negedge clk);
        start = 1'b0; nonce = nn;
      end
    end
    for (int i = 0; i < nmsg; i++) drive(msg_in[i], (i == nmsg - 1) ? lmsg : 8, i == nmsg - 1);
    while (tags_seen != target) @(negedge clk);
    @(negedge clk);
    chk(tag === s, "R7 tag held", tag, s);
    chk(!in_ready, "R7 idle after tag", {127'd0, in_ready}, '0);
    chk(q_cin.size() == 0 && q_out.size() == 0, "R8 calls complete", 128'(q_cin.size()), '0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({in_ready, c_start, out_valid, tag_valid, tag_ok} === 5'b0, "R1 reset outputs",
        {123'd0, in_ready, c_start, out_valid, tag_valid, tag_ok}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!in_ready && !c_start, "R1 idle after reset", {126'd0, in_ready, c_start}, '0);

    for (int i = 0; i < 8; i++) begin
      ad_blk[i] = {32'(i * 32'h9e3779b9 + 7), 32'(i * 32'h85ebca6b + 3)};
      pt[i]     = {32'(i * 32'hc2b2ae35 + 11), 32'(i * 32'h27d4eb2f + 5)};
    end

    // R2 R3 R4: full blocks, two AD, three message
    for (int i = 0; i < 3; i++) msg_in[i] = pt[i];
    session(1'b0, 2, 3, 8, 8, 120'h0123_4567_89ab_cdef_0011_2233_4455_66, 0, 1'b0);
    // R5 R9: decrypt with the right tag
    for (int i = 0; i < 3; i++) msg_in[i] = ct[i];
    session(1'b1, 2, 3, 8, 8, 120'h0123_4567_89ab_cdef_0011_2233_4455_66, 1, 1'b0);

    // R6: short AD and short last message, junk in unused bytes
    for (int i = 0; i < 2; i++) msg_in[i] = pt[i + 3];
    session(1'b0, 1, 2, 3, 5, 120'hfeed_0bad_cafe_1234_5678_9abc_def0_11, 0, 1'b0);
    for (int i = 0; i < 2; i++) msg_in[i] = ct[i] | (~bmask((i == 1) ? 5 : 8) & 64'hdead_beef_f00d_5a5a);
    session(1'b1, 1, 2, 3, 5, 120'hfeed_0bad_cafe_1234_5678_9abc_def0_11, 1, 1'b0);
    // R9: single-bit wrong tag
    session(1'b1, 1, 2, 3, 5, 120'hfeed_0bad_cafe_1234_5678_9abc_def0_11, 2, 1'b0);

    // R10: stray start mid-session; R9: encrypt with matching reference tag keeps tag_ok low
    msg_in[0] = pt[6] | 64'h00ff_ffff_ffff_ffff;
    session(1'b0, 3, 1, 8, 1, 120'h5555_aaaa_5555_aaaa_5555_aaaa_5555_aa, 1, 1'b1);
    // R6: seven-byte last block in decryption, one-byte AD
    for (int i = 0; i < 4; i++) msg_in[i] = pt[i + 1] ^ 64'h0f0f;
    session(1'b0, 1, 4, 1, 7, 120'h1, 0, 1'b0);
    for (int i = 0; i < 4; i++) msg_in[i] = ct[i] | (i == 3 ? 64'hff : 64'h0);
    session(1'b1, 1, 4, 1, 7, 120'h1, 1, 1'b0);

    repeat (4) @(negedge clk);
    chk(!out_valid && !c_start && !tag_valid, "R8 quiet when idle", {125'd0, out_valid, c_start, tag_valid}, '0);
    summary();
  end
endmodule